// File: doc/BRIEF.md
# Conversion Sequencer with Control and Result Memory

This block schedules the conversions of a shared analog-to-digital core. A small control memory holds one entry per slot: an input channel number, a reference selection and an end-of-sequence marker. When a run starts, an internal pointer loads from the start-address input. For each conversion the block presents the channel and reference of the current entry to the timing controller and pulses a start strobe. When the controller reports completion, the block stores the result in the result slot with the same index as the entry.

Four run modes are supported: one conversion, one pass through a sequence, one entry converted again and again, and a sequence repeated. A run begins on a software start pulse or on a rising edge of a hardware trigger. When the auto-continue option is selected, each later conversion in the run begins as soon as the previous one completes. Otherwise each later conversion waits for a new trigger.

Clearing the enable input stops a run, and the point at which it stops depends on the mode. Each result slot has a pending flag, which is set when the slot is written and cleared when the slot is read. Writing a slot whose flag is still pending raises an overflow indication. The interrupt output is the OR of the pending flags, each gated by its own mask bit.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `busy`, `conv_start`, `irq` and `overflow` are 0, and the pending-flag register (address 0x20) reads 0.
- R2: A run's first conversion uses the entry selected by `start_addr`. Entry words at addresses 0x00–0x0F are encoded as bits [3:0] channel, bits [6:4] reference and bit 7 end-of-sequence. While `conv_start` is high, `conv_chan` and `conv_ref` carry the channel and reference fields of the current entry.
- R3: In sequence modes (`mode` 1 = sequence once, 3 = repeat sequence), the pointer advances by one after each completed conversion. A run in mode 1 ends after converting an entry whose end-of-sequence bit is set. Without auto-continue, each later conversion waits for a software start or a hardware trigger edge.
- R4: The pointer advances from entry 15 to entry 0 when entry 15 has no end-of-sequence bit.
- R5: In mode 2 (repeat one entry), every conversion uses the start entry and overwrites the same result slot.
- R6: In mode 0 (one conversion), after a run started by a hardware trigger, further hardware trigger edges are ignored until `enable` has been low. A software start is always accepted while `enable` is high.
- R7: When `multi_sample` and `pulse_sampling` are both high and `mode` is nonzero, each later conversion starts automatically, one cycle after the previous one completes.
- R8: When `enable` is cleared, a mode-0 conversion is abandoned at once and its result is not written. A mode-2 run stops after the conversion in progress. A sequence-mode run stops after the entry marked end-of-sequence.
- R9: With `mode` at 0 and `enable` low, any run stops on the next clock edge.
- R10: A written slot sets its flag, visible as a bit of register 0x20. Reading the slot at 0x10+n clears flag n. A write to a slot whose flag is set raises `overflow`, which reads as bit 0 at 0x21 and clears when 0x21 is read.
- R11: Writes to entries 0x00–0x0F and to the mask register 0x22 are ignored while `enable` is high.
- R12: `irq` is high exactly when some slot has both its pending flag and its mask bit (register 0x22) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears pending flag or overflow on read |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| enable | input | 1 | Run enable; also locks configuration |
| mode | input | 2 | Run mode 0..3 |
| start_addr | input | 4 | First entry of a run |
| multi_sample | input | 1 | Auto-continue option |
| pulse_sampling | input | 1 | Timer-controlled sampling selected |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | 1 | Hardware trigger, rising edge active |
| conv_start | output | 1 | One-cycle strobe to the timing controller |
| conv_chan | output | 4 | Channel number of the current entry |
| conv_ref | output | 3 | Reference selection of the current entry |
| conv_done | input | 1 | Conversion complete pulse |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| busy | output | 1 | A run is active |
| irq | output | 1 | Masked OR of pending flags |
| overflow | output | 1 | Sticky overflow indication |

## Verification
The hardest situations to reach come from a stop request that arrives while a conversion is in progress. One case is an abandoned single conversion: its completion pulse arrives only after the sequencer has gone idle, and that late pulse must write nothing. The other case is a cleared enable that falls inside an auto-continued repeat run, where exactly the conversion in flight must still land. The bench uses a timing-controller model with a fixed latency and a log of every strobe. It clears `enable` (and `mode`) on counted cycles relative to the logged strobes, then inspects the flags, the slots and the overflow bit through the register port.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int SLOTS = 16,
  parameter int CH_W  = 4,
  parameter int REF_W = 3,
  parameter int RES_W = 12,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [$clog2(SLOTS)+1:0]   reg_addr,
  input  logic [DW-1:0]              reg_wdata,
  output logic [DW-1:0]              reg_rdata,
  input  logic                       enable,
  input  logic [1:0]                 mode,
  input  logic [$clog2(SLOTS)-1:0]   start_addr,
  input  logic                       multi_sample,
  input  logic                       pulse_sampling,
  input  logic                       sw_start,
  input  logic                       hw_trig,
  output logic                       conv_start,
  output logic [CH_W-1:0]            conv_chan,
  output logic [REF_W-1:0]           conv_ref,
  input  logic                       conv_done,
  input  logic [RES_W-1:0]           conv_result,
  output logic                       busy,
  output logic                       irq,
  output logic                       overflow
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = CH_W + REF_W + 1;
  localparam logic [PW+1:0] A_FLG = (PW+2)'(2*SLOTS);
  localparam logic [PW+1:0] A_OVF = (PW+2)'(2*SLOTS + 1);
  localparam logic [PW+1:0] A_IE  = (PW+2)'(2*SLOTS + 2);
  localparam logic [1:0] M_ONE = 2'd0, M_SEQ = 2'd1, M_REP_ONE = 2'd2, M_REP_SEQ = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT} st_t;

  st_t            state;
  logic [CW-1:0]    ctrl [SLOTS];
  logic [RES_W-1:0] res  [SLOTS];
  logic [SLOTS-1:0] flags, ie;
  logic [PW-1:0]    ptr, start_q, nxt_ptr, rd_idx;
  logic [1:0]       cur_mode;
  logic             auto_q, armed, trig_q, ovf_q, cs_q;
  logic             trig_rise, go, abort, wr_res, cur_eos, finish, rd_res, cfg_ok;

  assign trig_rise = hw_trig & ~trig_q;
  assign cur_eos   = ctrl[ptr][CW-1];
  assign go        = (state == S_IDLE) && enable && (sw_start || (trig_rise && armed));
  assign abort     = (state != S_IDLE) && !enable && (mode == M_ONE || cur_mode == M_ONE);
  assign wr_res    = (state == S_CONV) && conv_done && !abort;
  assign rd_res    = reg_rd && (reg_addr[PW+1:PW] == 2'b01);
  assign rd_idx    = reg_addr[PW-1:0];
  assign cfg_ok    = reg_wr && !enable;

  assign conv_start = cs_q;
  assign conv_chan  = ctrl[ptr][CH_W-1:0];
  assign conv_ref   = ctrl[ptr][CW-2:CH_W];
  assign busy       = (state != S_IDLE);
  assign irq        = |(flags & ie);
  assign overflow   = ovf_q;

  always_comb begin
    finish  = 1'b1;
    nxt_ptr = ptr;
    case (cur_mode)
      M_ONE:     finish = 1'b1;
      M_SEQ:     begin finish = cur_eos; nxt_ptr = ptr + PW'(1); end
      M_REP_ONE: finish = !enable;
      default:   begin
        finish  = cur_eos && !enable;
        nxt_ptr = cur_eos ? start_q : ptr + PW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      start_q  <= '0;
      cur_mode <= M_ONE;
      auto_q   <= 1'b0;
      cs_q     <= 1'b0;
      armed    <= 1'b1;
      trig_q   <= 1'b0;
    end else begin
      cs_q   <= 1'b0;
      trig_q <= hw_trig;
      if (!enable) armed <= 1'b1;
      else if (go && !sw_start) armed <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          ptr      <= start_addr;
          start_q  <= start_addr;
          cur_mode <= mode;
          auto_q   <= multi_sample && pulse_sampling && (mode != M_ONE);
          cs_q     <= 1'b1;
          state    <= S_CONV;
        end
        S_CONV: begin
          if (abort) state <= S_IDLE;
          else if (conv_done) begin
            if (finish) state <= S_IDLE;
            else begin
              ptr <= nxt_ptr;
              if (auto_q) cs_q <= 1'b1;
              else state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (abort || (cur_mode == M_REP_ONE && !enable)) state <= S_IDLE;
          else if (sw_start || trig_rise) begin
            cs_q  <= 1'b1;
            state <= S_CONV;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        ctrl[i] <= '0;
        res[i]  <= '0;
      end
      flags <= '0;
      ie    <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cfg_ok && reg_addr[PW+1:PW] == 2'b00) ctrl[rd_idx] <= reg_wdata[CW-1:0];
      if (cfg_ok && reg_addr == A_IE) ie <= reg_wdata[SLOTS-1:0];
      if (wr_res) res[ptr] <= conv_result;
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_res && ptr == PW'(i)) flags[i] <= 1'b1;
        else if (rd_res && rd_idx == PW'(i)) flags[i] <= 1'b0;
      end
      if (wr_res && flags[ptr] && !(rd_res && rd_idx == ptr)) ovf_q <= 1'b1;
      else if (reg_rd && reg_addr == A_OVF) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[PW+1:PW])
      2'b00: reg_rdata = DW'(ctrl[rd_idx]);
      2'b01: reg_rdata = DW'(res[rd_idx]);
      default: begin
        if (reg_addr == A_FLG) reg_rdata = DW'(flags);
        else if (reg_addr == A_OVF) reg_rdata = DW'(ovf_q);
        else if (reg_addr == A_IE) reg_rdata = DW'(ie);
      end
    endcase
  end

  // R2: a run begins at the requested entry with a strobe
  a_r2_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (conv_start && ptr == $past(start_addr)));

  // R4: sequence modes step to the next entry, wrapping at the top
  a_r4_wrap_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_res && cur_mode[0] && !cur_eos) |=> (ptr == $past(ptr) + PW'(1)));

  // R5: repeat-one never leaves its entry
  a_r5_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_mode == M_REP_ONE) |-> (ptr == start_q));

  // R8: single conversion abandoned immediately
  a_r8_single_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable && cur_mode == M_ONE) |=> !busy);

  // R9: mode zero plus enable low halts anything
  a_r9_forced_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable && mode == M_ONE) |=> !busy);

  // R10: a stored result raises its flag; an unread rewrite raises overflow
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_res |=> flags[$past(ptr)]);
  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_res && flags[ptr] && !(rd_res && rd_idx == ptr)) |=> overflow);

  // R11: entries are frozen while enabled
  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && enable && reg_addr[PW+1:PW] == 2'b00)
      |=> (ctrl[$past(rd_idx)] == $past(ctrl[rd_idx])));
endmodule

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;
  localparam int LAT = 5;
  // {mode[1:0], start[3:0], expected conversions[4:0]}
  localparam logic [10:0] VEC [6] = '{
    {2'd1, 4'd0,  5'd3}, {2'd1, 4'd5, 5'd3}, {2'd1, 4'd13, 5'd6},
    {2'd1, 4'd12, 5'd1}, {2'd0, 4'd9, 5'd1}, {2'd1, 4'd8,  5'd5}};

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic enable = 0, multi_sample = 0, pulse_sampling = 0, sw_start = 0, hw_trig = 0;
  logic [1:0] mode = 0;
  logic [3:0] start_addr = 0;
  logic conv_start, conv_done = 0, busy, irq, overflow;
  logic [3:0] conv_chan;
  logic [2:0] conv_ref;
  logic [11:0] conv_result = 0;

  int tests = 0, fails = 0;
  int lg_chan [512], lg_ref [512], lg_res [512];
  int lg_n = 0, pend = 0, nxt_res = 0;

  always #2 clk = ~clk;

  conv_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable), .mode(mode),
    .start_addr(start_addr), .multi_sample(multi_sample), .pulse_sampling(pulse_sampling),
    .sw_start(sw_start), .hw_trig(hw_trig), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_ref(conv_ref), .conv_done(conv_done), .conv_result(conv_result), .busy(busy),
    .irq(irq), .overflow(overflow));

  // timing controller model: fixed latency, logs every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      conv_done = 1'b0;
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) begin conv_done = 1'b1; conv_result = 12'(nxt_res); end
      end
      if (conv_start && lg_n < 512) begin
        lg_chan[lg_n] = int'(conv_chan);
        lg_ref[lg_n]  = int'(conv_ref);
        nxt_res = (int'(conv_chan) << 8) | (lg_n & 255);
        lg_res[lg_n]  = nxt_res;
        lg_n = lg_n + 1;
        pend = LAT;
      end
    end
  end

  function automatic int ech(int i); return (i * 7 + 3) % 16; endfunction
  function automatic int eref(int i); return (i + 1) % 8; endfunction
  function automatic int eeos(int i); return (i == 2 || i == 7 || i == 12) ? 1 : 0; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 6'(a); reg_wdata = 16'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 6'(a); reg_rd = 1;
    #1 d = int'(reg_rdata);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_sw; @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0; endtask
  task automatic pulse_hw; @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0; endtask

  task automatic wait_idle;
    for (int t = 0; t < 400 && busy; t++) @(negedge clk);
  endtask

  task automatic wait_count(input int base, input int n);
    for (int t = 0; t < 400 && (lg_n - base) < n; t++) @(negedge clk);
  endtask

  task automatic drain;
    int d;
    for (int i = 0; i < 16; i++) rd(16 + i, d);
    rd(33, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, base, s, mask, w0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(conv_start == 0, "R1 conv_start", conv_start, 0);
    chk(irq == 0 && overflow == 0, "R1 irq/overflow", {irq, overflow}, 0);
    rd(32, d); chk(d == 0, "R1 flags", d, 0);

    for (int i = 0; i < 16; i++) wr(i, (eeos(i) << 7) | (eref(i) << 4) | ech(i));
    w0 = (eeos(0) << 7) | (eref(0) << 4) | ech(0);
    rd(0, d); chk(d == w0, "R11 entry readback", d, w0);

    // table of runs with auto-continue
    multi_sample = 1; pulse_sampling = 1;
    for (int v = 0; v < 6; v++) begin
      mode = VEC[v][10:9]; start_addr = VEC[v][8:5];
      @(negedge clk); enable = 1;
      base = lg_n;
      pulse_sw; wait_idle;
      enable = 0;
      chk(lg_n - base == int'(VEC[v][4:0]), (v == 2) ? "R4 wrap count" : "R7 R3 count",
          lg_n - base, int'(VEC[v][4:0]));
      s = int'(VEC[v][8:5]); mask = 0;
      for (int j = 0; j < int'(VEC[v][4:0]); j++) begin
        mask |= 1 << ((s + j) % 16);
      end
      rd(32, d); chk(d == mask, "R10 flags after run", d, mask);
      for (int j = 0; j < int'(VEC[v][4:0]); j++) begin
        chk(lg_chan[base + j] == ech(s), "R2 channel", lg_chan[base + j], ech(s));
        chk(lg_ref[base + j] == eref(s), "R2 reference", lg_ref[base + j], eref(s));
        rd(16 + s, d); chk(d == lg_res[base + j], "R3 stored result", d, lg_res[base + j]);
        s = (s + 1) % 16;
      end
      rd(32, d); chk(d == 0, "R10 read clears flags", d, 0);
      chk(overflow == 0, "R10 no overflow", overflow, 0);
    end

    // R3 sequence without auto-continue waits for triggers
    multi_sample = 0; mode = 1; start_addr = 0;
    @(negedge clk); enable = 1; base = lg_n;
    pulse_sw; repeat (12) @(negedge clk);
    chk(busy == 1 && lg_n - base == 1, "R3 waits for trigger", lg_n - base, 1);
    pulse_hw; repeat (12) @(negedge clk);
    chk(lg_n - base == 2, "R3 hw trigger advances", lg_n - base, 2);
    pulse_sw; wait_idle;
    chk(lg_n - base == 3 && busy == 0, "R3 ends at marker", lg_n - base, 3);
    enable = 0; drain;

    // R6 re-arm rule
    mode = 0; start_addr = 4;
    @(negedge clk); enable = 1; base = lg_n;
    pulse_hw; wait_idle;
    chk(lg_n - base == 1, "R6 first hw run", lg_n - base, 1);
    pulse_hw; repeat (10) @(negedge clk);
    chk(lg_n - base == 1 && busy == 0, "R6 hw ignored", lg_n - base, 1);
    pulse_sw; wait_idle;
    chk(lg_n - base == 2, "R6 sw accepted", lg_n - base, 2);
    enable = 0; @(negedge clk); enable = 1;
    pulse_hw; wait_idle;
    chk(lg_n - base == 3, "R6 hw after toggle", lg_n - base, 3);
    enable = 0;
    chk(overflow == 1, "R10 overflow on rewrite", overflow, 1);
    rd(33, d); chk(d == 1, "R10 overflow readback", d, 1);
    @(negedge clk); chk(overflow == 0, "R10 overflow cleared", overflow, 0);
    drain;

    // R5 repeat one entry, stop after conversion in flight
    mode = 2; start_addr = 6; multi_sample = 1;
    @(negedge clk); enable = 1; base = lg_n;
    pulse_sw; wait_count(base, 3);
    enable = 0; wait_idle;
    for (int j = base; j < lg_n; j++) chk(lg_chan[j] == ech(6), "R5 same entry", lg_chan[j], ech(6));
    rd(32, d); chk(d == (1 << 6), "R5 single slot flag", d, 1 << 6);
    rd(22, d); chk(d == lg_res[lg_n - 1], "R8 last conversion stored", d, lg_res[lg_n - 1]);
    chk(overflow == 1, "R10 repeat overflow", overflow, 1);
    drain;

    // R8 single conversion abandoned
    mode = 0; start_addr = 1; multi_sample = 0;
    @(negedge clk); enable = 1;
    pulse_sw; repeat (2) @(negedge clk);
    enable = 0; @(negedge clk);
    chk(busy == 0, "R8 immediate stop", busy, 0);
    repeat (10) @(negedge clk);
    rd(32, d); chk(d == 0, "R8 abandoned result not written", d, 0);

    // R9 forced stop of a repeat sequence
    mode = 3; start_addr = 0; multi_sample = 1;
    @(negedge clk); enable = 1; base = lg_n;
    pulse_sw; wait_count(base, 2);
    mode = 0; enable = 0; @(negedge clk);
    chk(busy == 0, "R9 forced stop", busy, 0);
    repeat (10) @(negedge clk); drain;

    // R8 repeat sequence finishes its pass
    mode = 3; start_addr = 5;
    @(negedge clk); enable = 1; base = lg_n;
    pulse_sw; enable = 0; wait_idle;
    chk(lg_n - base == 3, "R8 sequence completes", lg_n - base, 3);
    rd(32, d); chk(d == 32'h00e0, "R8 sequence slots", d, 32'h00e0);
    drain;

    // R11 lock and R12 interrupt masking
    wr(34, 1 << 3);
    @(negedge clk); enable = 1;
    wr(0, 16'h00ff); wr(34, 16'hffff);
    enable = 0;
    rd(0, d); chk(d == w0, "R11 entry write ignored", d, w0);
    rd(34, d); chk(d == 8, "R11 mask write ignored", d, 8);
    mode = 0; multi_sample = 0; start_addr = 4;
    @(negedge clk); enable = 1;
    pulse_sw; wait_idle;
    chk(irq == 0, "R12 masked slot", irq, 0);
    start_addr = 3;
    pulse_sw; wait_idle;
    chk(irq == 1, "R12 unmasked slot", irq, 1);
    rd(19, d);
    chk(irq == 0, "R12 cleared by read", irq, 0);
    enable = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule